// File: doc/BRIEF.md
# Static Branch Predictor with Speculation Flush

This block sits next to an instruction queue and decides what fetch does with each branch it is offered. A branch whose condition is already known, and an unconditional branch, are steered at once to the right address and need no guess. A conditional branch whose condition is still pending is guessed from the static hint bit carried in the instruction. It is then held in a single slot until the condition arrives. While the slot is occupied, every instruction fetched is tagged as conditional.

A register-indirect branch (target in the link or count register) is not accepted while its target value is not yet available, so fetch stalls on it. When the held branch resolves, the block compares the real outcome with the guess. A match releases the conditional tag. A mismatch raises a flush strobe and, in the same cycle, gives the address fetch must restart from.

Top module: `static_branch_steer`

## Requirements
- R1: After reset no branch is held: `spec_tag`, `fetch_cond`, `flush` and `commit` are all 0.
- R2: A conditional branch offered with `cond_ready`=1 is accepted in the same cycle with `steer_valid`=1 and `steer_predicted`=0. `steer_pc` is `br_target` when `cond_taken`=1 and `br_pc`+4 otherwise, and no branch is held afterwards.
- R3: A conditional branch offered with `cond_ready`=0 and nothing held is accepted with `steer_predicted`=1. `steer_taken` equals `hint_taken`, and `steer_pc` is `br_target` for hint 1 and `br_pc`+4 for hint 0. From the next cycle `spec_tag`=1.
- R4: A branch with `br_indirect`=1 and `tgt_ready`=0 raises `issue_stall`, keeps `steer_valid` at 0 and changes no held state.
- R5: While a branch is held (from the cycle after its issue), `fetch_cond` equals `fetch_valid`. With nothing held, `fetch_cond` is 0.
- R6: While a branch is held, a second branch with `cond_ready`=0 is stalled. A branch with `cond_ready`=1 is still accepted.
- R7: When `res_valid`=1 and `res_taken` differs from the held guess, `flush`=1 in that cycle. `flush_pc` is the held target if `res_taken`=1 and the held fall-through (`br_pc`+4) otherwise. From the next cycle nothing is held.
- R8: When `res_valid`=1 and `res_taken` equals the held guess, `commit`=1 and `flush`=0 in that cycle, and from the next cycle `spec_tag` and `fetch_cond` are 0.
- R9: `res_valid` with nothing held has no effect: `flush` and `commit` stay 0.
- R10: A branch with `br_uncond`=1 is steered to `br_target` as taken and not predicted, whatever `cond_ready` and `hint_taken` are.
- R11: A branch offered in a cycle with `flush`=1 is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch is offered for issue |
| br_uncond | input | 1 | Branch is unconditional |
| br_indirect | input | 1 | Target comes from the link or count register |
| tgt_ready | input | 1 | Indirect target value is available |
| cond_ready | input | 1 | Branch condition is available at issue |
| cond_taken | input | 1 | Condition outcome when available |
| hint_taken | input | 1 | Static hint: 1 = guess taken |
| br_pc | input | ADDR_W | Address of the branch |
| br_target | input | ADDR_W | Branch target address |
| res_valid | input | 1 | Condition of the held branch arrives |
| res_taken | input | 1 | Real outcome of the held branch |
| fetch_valid | input | 1 | An instruction is fetched this cycle |
| issue_stall | output | 1 | Offered branch is not accepted |
| steer_valid | output | 1 | Branch accepted; steer fields valid |
| steer_predicted | output | 1 | Direction is a guess |
| steer_taken | output | 1 | Chosen direction |
| steer_pc | output | ADDR_W | Next fetch address |
| spec_tag | output | 1 | A guessed branch is held |
| fetch_cond | output | 1 | The fetched instruction is conditional |
| commit | output | 1 | Held guess proved right |
| flush | output | 1 | Held guess proved wrong; discard conditional work |
| flush_pc | output | ADDR_W | Restart address for fetch |

## Verification
Resolved branches are driven with both outcomes so that target and fall-through steering are told apart. Unresolved branches are driven with both hint values, and each is later resolved both ways: the four hint/outcome pairs separate commit from flush and select which held address is restored. Indirect branches are offered with and without a ready target, and branches arrive while another is held and during a flush cycle. Together these show that stalls come only from the listed causes.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    ROUTE_HOLD      = 2'd0,
    ROUTE_RESOLVED  = 2'd1,
    ROUTE_PREDICTED = 2'd2
  } route_e;
endpackage

// File: rtl/sbs_rst_sync.sv
module sbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sbs_issue_ctl.sv
module sbs_issue_ctl
  import sbs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              br_valid,
  input  logic              br_uncond,
  input  logic              br_indirect,
  input  logic              tgt_ready,
  input  logic              cond_ready,
  input  logic              cond_taken,
  input  logic              hint_taken,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              slot_busy,
  input  logic              flushing,
  output route_e            route,
  output logic              stall,
  output logic              dir_taken,
  output logic [ADDR_W-1:0] next_pc,
  output logic [ADDR_W-1:0] fall_pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic needs_guess;
  logic tgt_block;
  logic slot_block;

  always_comb begin
    needs_guess = !br_uncond && !cond_ready;
    tgt_block   = br_indirect && !tgt_ready;
    slot_block  = needs_guess && slot_busy;
    stall       = br_valid && (tgt_block || slot_block || flushing);

    if (!br_valid || stall) route = ROUTE_HOLD;
    else if (needs_guess)   route = ROUTE_PREDICTED;
    else                    route = ROUTE_RESOLVED;

    if (br_uncond)       dir_taken = 1'b1;
    else if (cond_ready) dir_taken = cond_taken;
    else                 dir_taken = hint_taken;

    fall_pc = br_pc + STEP;
    next_pc = dir_taken ? br_target : fall_pc;
  end
endmodule

// File: rtl/sbs_spec_slot.sv
module sbs_spec_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              load,
  input  logic              release_slot,
  input  logic              guess_in,
  input  logic [ADDR_W-1:0] tgt_in,
  input  logic [ADDR_W-1:0] fall_in,
  output logic              busy,
  output logic              guess,
  output logic [ADDR_W-1:0] tgt,
  output logic [ADDR_W-1:0] fall
);
  logic              busy_q, busy_d;
  logic              guess_q;
  logic [ADDR_W-1:0] tgt_q, fall_q;
  logic              data_en;

  always_comb begin
    busy_d  = busy_q;
    if (release_slot) busy_d = 1'b0;
    if (load)         busy_d = 1'b1;
    data_en = load;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) busy_q <= 1'b0;
    else         busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      guess_q <= 1'b0;
      tgt_q   <= '0;
      fall_q  <= '0;
    end else if (data_en) begin
      guess_q <= guess_in;
      tgt_q   <= tgt_in;
      fall_q  <= fall_in;
    end
  end

  assign busy  = busy_q;
  assign guess = guess_q;
  assign tgt   = tgt_q;
  assign fall  = fall_q;
endmodule

// File: rtl/sbs_resolve.sv
module sbs_resolve #(
  parameter int ADDR_W = 32
) (
  input  logic              res_valid,
  input  logic              res_taken,
  input  logic              busy,
  input  logic              guess,
  input  logic [ADDR_W-1:0] tgt,
  input  logic [ADDR_W-1:0] fall,
  output logic              settle,
  output logic              wrong,
  output logic              right,
  output logic [ADDR_W-1:0] restart_pc
);
  always_comb begin
    settle     = res_valid && busy;
    wrong      = settle && (res_taken != guess);
    right      = settle && (res_taken == guess);
    restart_pc = res_taken ? tgt : fall;
  end
endmodule

// File: rtl/static_branch_steer.sv
module static_branch_steer
  import sbs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic              br_uncond,
  input  logic              br_indirect,
  input  logic              tgt_ready,
  input  logic              cond_ready,
  input  logic              cond_taken,
  input  logic              hint_taken,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              res_valid,
  input  logic              res_taken,
  input  logic              fetch_valid,
  output logic              issue_stall,
  output logic              steer_valid,
  output logic              steer_predicted,
  output logic              steer_taken,
  output logic [ADDR_W-1:0] steer_pc,
  output logic              spec_tag,
  output logic              fetch_cond,
  output logic              commit,
  output logic              flush,
  output logic [ADDR_W-1:0] flush_pc
);
  logic              srst_n;
  route_e            route;
  logic              dir_taken;
  logic [ADDR_W-1:0] next_pc, fall_pc;
  logic              busy, guess;
  logic [ADDR_W-1:0] held_tgt, held_fall;
  logic              settle, wrong, right;
  logic [ADDR_W-1:0] restart_pc;

  sbs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  sbs_issue_ctl #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_issue (
    .br_valid(br_valid), .br_uncond(br_uncond), .br_indirect(br_indirect),
    .tgt_ready(tgt_ready), .cond_ready(cond_ready), .cond_taken(cond_taken),
    .hint_taken(hint_taken), .br_pc(br_pc), .br_target(br_target),
    .slot_busy(busy), .flushing(wrong), .route(route), .stall(issue_stall),
    .dir_taken(dir_taken), .next_pc(next_pc), .fall_pc(fall_pc)
  );

  sbs_spec_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk(clk), .srst_n(srst_n), .load(route == ROUTE_PREDICTED),
    .release_slot(settle), .guess_in(dir_taken), .tgt_in(br_target),
    .fall_in(fall_pc), .busy(busy), .guess(guess), .tgt(held_tgt),
    .fall(held_fall)
  );

  sbs_resolve #(.ADDR_W(ADDR_W)) u_res (
    .res_valid(res_valid), .res_taken(res_taken), .busy(busy), .guess(guess),
    .tgt(held_tgt), .fall(held_fall), .settle(settle), .wrong(wrong),
    .right(right), .restart_pc(restart_pc)
  );

  always_comb begin
    steer_valid     = (route != ROUTE_HOLD);
    steer_predicted = (route == ROUTE_PREDICTED);
    steer_taken     = steer_valid && dir_taken;
    steer_pc        = next_pc;
    spec_tag        = busy;
    fetch_cond      = fetch_valid && busy;
    commit          = right;
    flush           = wrong;
    flush_pc        = restart_pc;
  end
endmodule

// File: rtl/static_branch_steer_chk.sv
module static_branch_steer_chk (
  input logic clk,
  input logic srst_n,
  input logic br_valid,
  input logic br_indirect,
  input logic tgt_ready,
  input logic cond_ready,
  input logic br_uncond,
  input logic issue_stall,
  input logic steer_valid,
  input logic steer_predicted,
  input logic spec_tag,
  input logic fetch_valid,
  input logic fetch_cond,
  input logic commit,
  input logic flush
);
  a_r4_indirect_waits: assert property (@(posedge clk) disable iff (!srst_n)
    (br_valid && br_indirect && !tgt_ready) |-> (issue_stall && !steer_valid));

  a_r3_guess_is_held: assert property (@(posedge clk) disable iff (!srst_n)
    steer_predicted |=> spec_tag);

  a_r5_tag_only_when_held: assert property (@(posedge clk) disable iff (!srst_n)
    fetch_cond |-> (fetch_valid && spec_tag));

  a_r6_one_guess_at_a_time: assert property (@(posedge clk) disable iff (!srst_n)
    (spec_tag && br_valid && !cond_ready && !br_uncond) |-> issue_stall);

  a_r7_flush_frees_slot: assert property (@(posedge clk) disable iff (!srst_n)
    flush |=> !spec_tag);

  a_r8_commit_frees_slot: assert property (@(posedge clk) disable iff (!srst_n)
    commit |=> !spec_tag);

  a_r9_idle_no_outcome: assert property (@(posedge clk) disable iff (!srst_n)
    !spec_tag |-> (!flush && !commit));

  a_r11_no_issue_in_flush: assert property (@(posedge clk) disable iff (!srst_n)
    flush |-> !steer_valid);
endmodule

bind static_branch_steer static_branch_steer_chk u_chk (
  .clk(clk), .srst_n(srst_n), .br_valid(br_valid), .br_indirect(br_indirect),
  .tgt_ready(tgt_ready), .cond_ready(cond_ready), .br_uncond(br_uncond),
  .issue_stall(issue_stall), .steer_valid(steer_valid),
  .steer_predicted(steer_predicted), .spec_tag(spec_tag),
  .fetch_valid(fetch_valid), .fetch_cond(fetch_cond), .commit(commit),
  .flush(flush)
);

// File: tb/sim_static_branch_steer.sv
`timescale 1ns/1ps
module sim_static_branch_steer;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic br_valid, br_uncond, br_indirect, tgt_ready, cond_ready, cond_taken, hint_taken;
  logic [AW-1:0] br_pc, br_target;
  logic res_valid, res_taken, fetch_valid;
  logic issue_stall, steer_valid, steer_predicted, steer_taken;
  logic [AW-1:0] steer_pc, flush_pc;
  logic spec_tag, fetch_cond, commit, flush;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  static_branch_steer u0 (.*);

  task automatic chk(input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    br_valid = 0; br_uncond = 0; br_indirect = 0; tgt_ready = 0;
    cond_ready = 0; cond_taken = 0; hint_taken = 0;
    br_pc = '0; br_target = '0; res_valid = 0; res_taken = 0; fetch_valid = 0;
  endtask

  task automatic offer(input logic unc, input logic ind, input logic trdy,
                       input logic crdy, input logic ctk, input logic hint,
                       input logic [AW-1:0] pc, input logic [AW-1:0] tgt);
    br_valid = 1; br_uncond = unc; br_indirect = ind; tgt_ready = trdy;
    cond_ready = crdy; cond_taken = ctk; hint_taken = hint;
    br_pc = pc; br_target = tgt;
  endtask

  // drive at negedge, let combinational outputs settle
  task automatic cyc();
    @(negedge clk);
    quiet();
  endtask

  task automatic t_reset();
    #2;
    chk("R1", "spec_tag", AW'(spec_tag), 0);
    chk("R1", "flush", AW'(flush), 0);
    chk("R1", "commit", AW'(commit), 0);
    fetch_valid = 1; #1;
    chk("R1", "fetch_cond", AW'(fetch_cond), 0);
  endtask

  task automatic t_resolved();
    cyc(); offer(0, 0, 0, 1, 1, 0, 32'h100, 32'h800); #2;
    chk("R2", "valid", AW'(steer_valid), 1);
    chk("R2", "predicted", AW'(steer_predicted), 0);
    chk("R2", "pc taken", steer_pc, 32'h800);
    cyc(); offer(0, 0, 0, 1, 0, 1, 32'h200, 32'h900); #2;
    chk("R2", "pc not taken", steer_pc, 32'h204);
    chk("R2", "taken", AW'(steer_taken), 0);
    cyc(); #2;
    chk("R2", "no slot", AW'(spec_tag), 0);
  endtask

  task automatic t_uncond();
    cyc(); offer(1, 0, 0, 0, 0, 0, 32'h300, 32'hA00); #2;
    chk("R10", "predicted", AW'(steer_predicted), 0);
    chk("R10", "taken", AW'(steer_taken), 1);
    chk("R10", "pc", steer_pc, 32'hA00);
    cyc(); #2;
    chk("R10", "no slot", AW'(spec_tag), 0);
  endtask

  task automatic t_indirect();
    cyc(); offer(0, 1, 0, 0, 0, 1, 32'h400, 32'hB00); #2;
    chk("R4", "stall", AW'(issue_stall), 1);
    chk("R4", "valid", AW'(steer_valid), 0);
    cyc(); #2;
    chk("R4", "no slot", AW'(spec_tag), 0);
    offer(0, 1, 1, 0, 0, 1, 32'h400, 32'hB00); #2;
    chk("R4", "ready target accepted", AW'(steer_predicted), 1);
    cyc(); res_valid = 1; res_taken = 1; #2;
    chk("R8", "commit after indirect", AW'(commit), 1);
    cyc();
  endtask

  task automatic t_correct();
    cyc(); offer(0, 0, 0, 0, 0, 1, 32'h500, 32'hC00); fetch_valid = 1; #2;
    chk("R3", "predicted", AW'(steer_predicted), 1);
    chk("R3", "pc hint taken", steer_pc, 32'hC00);
    chk("R5", "issue cycle not tagged", AW'(fetch_cond), 0);
    cyc(); fetch_valid = 1; #2;
    chk("R3", "held", AW'(spec_tag), 1);
    chk("R5", "tagged", AW'(fetch_cond), 1);
    fetch_valid = 0; #1;
    chk("R5", "no fetch no tag", AW'(fetch_cond), 0);
    cyc(); res_valid = 1; res_taken = 1; #2;
    chk("R8", "commit", AW'(commit), 1);
    chk("R8", "no flush", AW'(flush), 0);
    cyc(); fetch_valid = 1; #2;
    chk("R8", "released", AW'(spec_tag), 0);
    chk("R8", "fetch_cond", AW'(fetch_cond), 0);
  endtask

  task automatic t_wrong_taken();
    cyc(); offer(0, 0, 0, 0, 0, 0, 32'h600, 32'hD00); #2;
    chk("R3", "pc hint not taken", steer_pc, 32'h604);
    chk("R3", "taken", AW'(steer_taken), 0);
    cyc(); res_valid = 1; res_taken = 1; #2;
    chk("R7", "flush", AW'(flush), 1);
    chk("R7", "flush_pc target", flush_pc, 32'hD00);
    chk("R7", "no commit", AW'(commit), 0);
    cyc(); #2;
    chk("R7", "released", AW'(spec_tag), 0);
  endtask

  task automatic t_wrong_fall();
    cyc(); offer(0, 0, 0, 0, 0, 1, 32'h700, 32'hE00);
    cyc(); res_valid = 1; res_taken = 0; #2;
    chk("R7", "flush", AW'(flush), 1);
    chk("R7", "flush_pc fall-through", flush_pc, 32'h704);
    cyc(); #2;
    chk("R7", "released", AW'(spec_tag), 0);
  endtask

  task automatic t_second();
    cyc(); offer(0, 0, 0, 0, 0, 0, 32'h1000, 32'h2000);
    cyc(); offer(0, 0, 0, 0, 0, 1, 32'h1100, 32'h2100); #2;
    chk("R6", "second guess stalls", AW'(issue_stall), 1);
    chk("R6", "no steer", AW'(steer_valid), 0);
    offer(0, 0, 0, 1, 1, 0, 32'h1100, 32'h2100); #2;
    chk("R6", "resolved passes", AW'(steer_valid), 1);
    chk("R6", "resolved pc", steer_pc, 32'h2100);
    cyc(); res_valid = 1; res_taken = 0; #2;
    chk("R8", "first still held and commits", AW'(commit), 1);
    cyc();
  endtask

  task automatic t_flush_block();
    cyc(); offer(0, 0, 0, 0, 0, 1, 32'h3000, 32'h4000);
    cyc(); res_valid = 1; res_taken = 0;
    offer(0, 0, 0, 1, 1, 0, 32'h3100, 32'h5000); #2;
    chk("R11", "flush", AW'(flush), 1);
    chk("R11", "stall", AW'(issue_stall), 1);
    chk("R11", "no steer", AW'(steer_valid), 0);
    cyc();
  endtask

  task automatic t_ignored();
    cyc(); res_valid = 1; res_taken = 1; #2;
    chk("R9", "flush", AW'(flush), 0);
    chk("R9", "commit", AW'(commit), 0);
    res_taken = 0; #1;
    chk("R9", "flush nt", AW'(flush), 0);
    cyc(); #2;
    chk("R9", "state", AW'(spec_tag), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    quiet();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_resolved();
    t_uncond();
    t_indirect();
    t_correct();
    t_wrong_taken();
    t_wrong_fall();
    t_second();
    t_flush_block();
    t_ignored();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule